// File: doc/BRIEF.md
# Instruction clock pulse count validator

This block guards a serial-access memory against clock glitches. It counts the serial clock rising edges of one instruction frame, starting with the edge that sampled the start bit and ending when chip select falls. At that moment it compares the total with the length that the decoded instruction class and the configured address width call for. For instructions that change stored state it then issues either a commit pulse, which lets the memory update proceed, or an abort pulse, which leaves everything unchanged.

A single stray clock pulse shifts every later address and data bit by one position. Exact matching of the count catches this before any damage is done. Page writes have a variable length, so the block also reports how many whole 16-bit data words arrived after the header. Instruction decoding and the memory itself are handled by neighbouring logic. All inputs are single-cycle event strobes in the system clock domain, and all outputs are registered.

Top module: `clk_count_validator`

## Requirements
- R1: After reset, `commit` and `abort` are low and `page_words` is 0.
- R2: `start_seen` loads the count with 1, whether or not `sclk_rise` is high in the same cycle. Each later `sclk_rise` adds 1, however many idle cycles lie between rises. A `sclk_rise` while no frame is open is ignored.
- R3: Write (`instr_cls` = 2) and write-all (`instr_cls` = 3) match a count of 3 + address bits + 16. That is 25 when `addr_wide` = 0 (6-bit address) and 27 when `addr_wide` = 1 (8-bit address).
- R4: Page write (`instr_cls` = 4) matches 9 + 16·N when `addr_wide` = 0, and 11 + 16·N when `addr_wide` = 1, for N from 1 to 4 only.
- R5: Control-class instructions (`instr_cls` = 5: enable, disable, boundary set, boundary clear, arm, lock) match 9 clocks when `addr_wide` = 0 and 11 clocks when `addr_wide` = 1.
- R6: A modifying class (2 to 5) whose count does not match raises `abort`, never `commit`. One pulse too many or one too few is enough to cause this.
- R7: Read (`instr_cls` = 1) and no-instruction (`instr_cls` = 0) frames never raise `commit` or `abort`, whatever the count.
- R8: The count saturates at 2^CNT_W−1 (255 by default) and does not wrap. A very long burst therefore cannot alias onto a matching length.
- R9: `commit` or `abort` is high for exactly one cycle, in the cycle after the clock edge that samples `sel_fall` on an open frame.
- R10: When that same edge closes a frame, `page_words` loads floor((count − header)/16), where header is 9 or 11. The value is 0 if the count is below the header and is clipped to 7. `page_words` holds its value at all other times.
- R11: A `sel_fall` with no open frame produces no pulse and leaves `page_words` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_seen | input | 1 | Start bit detected on this serial clock edge; opens a frame |
| sclk_rise | input | 1 | Serial clock rising-edge strobe |
| sel_fall | input | 1 | Chip select falling-edge strobe; closes the frame |
| instr_cls | input | 3 | Decoded class: 0 none, 1 read, 2 write, 3 write-all, 4 page write, 5 control |
| addr_wide | input | 1 | 0: 6-bit address, 1: 8-bit address |
| commit | output | 1 | One-cycle pulse: modifying instruction had the exact length |
| abort | output | 1 | One-cycle pulse: modifying instruction length mismatch |
| page_words | output | 3 | Whole data words received after the header in the last frame |

## Verification
Every result of this block (the commit or abort pulse and the new `page_words` value) is due in the cycle that follows the clock edge sampling `sel_fall`. The count itself has no visible latency, because a rise sampled on the closing edge is already included. The bench drives strobes on the falling clock edge. A behavioural model advances on the rising edge, and both outputs and model are compared at the next falling edge, the first point at which the registered verdict is stable. Scenario checks look at the pulse in that cycle and confirm it is gone one cycle later.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_READ  = 3'd1,
    CLS_WRITE = 3'd2,
    CLS_WRALL = 3'd3,
    CLS_PAGE  = 3'd4,
    CLS_CTRL  = 3'd5
  } instr_cls_e;

  // start bit + two opcode bits + address field
  function automatic int unsigned header_len(input logic wide,
                                             input int unsigned narrow_bits,
                                             input int unsigned wide_bits);
    return 3 + (wide ? wide_bits : narrow_bits);
  endfunction

  // header followed by n data words
  function automatic int unsigned frame_len(input int unsigned hdr,
                                            input int unsigned n_words,
                                            input int unsigned word_bits);
    return hdr + n_words * word_bits;
  endfunction

  function automatic logic is_modifying(input instr_cls_e c);
    return (c == CLS_WRITE) || (c == CLS_WRALL) || (c == CLS_PAGE) || (c == CLS_CTRL);
  endfunction

endpackage

// File: rtl/pcv_edge_counter.sv
module pcv_edge_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_seen,
  input  logic             sclk_rise,
  input  logic             frame_close,
  output logic [CNT_W-1:0] cnt_eff,
  output logic             open_eff
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             open_q;
  logic             bump;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign bump   = open_q && sclk_rise && !start_seen;

  // count as seen by this edge, including a rise sampled now
  always_comb begin
    if (start_seen) begin
      cnt_eff  = CNT_W'(1);
      open_eff = 1'b1;
    end else begin
      cnt_eff  = (bump && !at_max) ? cnt_q + CNT_W'(1) : cnt_q;
      open_eff = open_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (frame_close) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_eff;
      open_q <= open_eff;
    end
  end

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && at_max && !frame_close) |=> (cnt_q == CNT_MAX));

  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !at_max && !frame_close) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r2_start_loads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !frame_close) |=> (cnt_q == CNT_W'(1)) && open_q);

endmodule

// File: rtl/pcv_length_judge.sv
module pcv_length_judge
  import pcv_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WORD_BITS   = 16,
  parameter int unsigned NARROW_ADDR = 6,
  parameter int unsigned WIDE_ADDR   = 8,
  parameter int unsigned MAX_PAGE    = 4,
  parameter int unsigned PW_W        = 3
) (
  input  instr_cls_e       cls,
  input  logic             addr_wide,
  input  logic [CNT_W-1:0] cnt,
  output logic             len_match,
  output logic [PW_W-1:0]  words
);
  localparam int unsigned PW_MAX = (1 << PW_W) - 1;

  logic [CNT_W-1:0]    hdr;
  logic [CNT_W-1:0]    single_len;
  logic [CNT_W-1:0]    above;
  logic [CNT_W-1:0]    words_raw;
  logic [MAX_PAGE-1:0] page_hit;

  assign hdr        = CNT_W'(header_len(addr_wide, NARROW_ADDR, WIDE_ADDR));
  assign single_len = hdr + CNT_W'(frame_len(0, 1, WORD_BITS));

  // one comparator per legal page length
  for (genvar g = 0; g < MAX_PAGE; g++) begin : g_page
    assign page_hit[g] = (cnt == hdr + CNT_W'(frame_len(0, g + 1, WORD_BITS)));
  end

  always_comb begin
    case (cls)
      CLS_WRITE, CLS_WRALL: len_match = (cnt == single_len);
      CLS_PAGE:             len_match = |page_hit;
      CLS_CTRL:             len_match = (cnt == hdr);
      default:              len_match = 1'b0;
    endcase
  end

  assign above     = (cnt >= hdr) ? cnt - hdr : '0;
  assign words_raw = above / CNT_W'(WORD_BITS);
  assign words     = (words_raw > CNT_W'(PW_MAX)) ? PW_W'(PW_MAX) : words_raw[PW_W-1:0];

endmodule

// File: rtl/clk_count_validator.sv
module clk_count_validator
  import pcv_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WORD_BITS   = 16,
  parameter int unsigned NARROW_ADDR = 6,
  parameter int unsigned WIDE_ADDR   = 8,
  parameter int unsigned MAX_PAGE    = 4,
  parameter int unsigned PW_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_seen,
  input  logic            sclk_rise,
  input  logic            sel_fall,
  input  logic [2:0]      instr_cls,
  input  logic            addr_wide,
  output logic            commit,
  output logic            abort,
  output logic [PW_W-1:0] page_words
);
  instr_cls_e       cls;
  logic [CNT_W-1:0] cnt_eff;
  logic             open_eff;
  logic             frame_end;
  logic             modifying;
  logic             len_match;
  logic [PW_W-1:0]  words;

  assign cls       = instr_cls_e'(instr_cls);
  assign frame_end = sel_fall && open_eff;
  assign modifying = is_modifying(cls);

  pcv_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_seen  (start_seen),
    .sclk_rise   (sclk_rise),
    .frame_close (sel_fall),
    .cnt_eff     (cnt_eff),
    .open_eff    (open_eff)
  );

  pcv_length_judge #(
    .CNT_W       (CNT_W),
    .WORD_BITS   (WORD_BITS),
    .NARROW_ADDR (NARROW_ADDR),
    .WIDE_ADDR   (WIDE_ADDR),
    .MAX_PAGE    (MAX_PAGE),
    .PW_W        (PW_W)
  ) u_judge (
    .cls       (cls),
    .addr_wide (addr_wide),
    .cnt       (cnt_eff),
    .len_match (len_match),
    .words     (words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit     <= 1'b0;
      abort      <= 1'b0;
      page_words <= '0;
    end else begin
      commit <= frame_end && modifying && len_match;
      abort  <= frame_end && modifying && !len_match;
      if (frame_end) page_words <= words;
    end
  end

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort));

  a_r9_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |-> $past(sel_fall));

  a_r7_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall && (cls == CLS_READ || cls == CLS_NONE)) |=> !commit && !abort);

  a_r11_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall && !open_eff) |=> !commit && !abort && $stable(page_words));

endmodule

// File: tb/clk_count_validator_test.sv
module clk_count_validator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, rise_i = 1'b0, sel_i = 1'b0, wide_i = 1'b0;
  logic [2:0] cls_i = 3'd0;
  logic       commit, abort;
  logic [2:0] page_words;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clk_count_validator uut (
    .clk(clk), .rst_n(rst_n), .start_seen(start_i), .sclk_rise(rise_i),
    .sel_fall(sel_i), .instr_cls(cls_i), .addr_wide(wide_i),
    .commit(commit), .abort(abort), .page_words(page_words)
  );

  // behavioural reference model
  int m_cnt = 0;
  bit m_open = 0;
  bit e_commit = 0, e_abort = 0;
  int e_pw = 0;

  always @(posedge clk) begin
    int c, hdr, above, w;
    bit o, ok, modif;
    if (!rst_n) begin
      m_cnt = 0; m_open = 0; e_commit = 0; e_abort = 0; e_pw = 0;
    end else begin
      c = m_cnt; o = m_open;
      if (start_i) begin c = 1; o = 1; end
      else if (rise_i && o && c < 255) c = c + 1;
      e_commit = 0; e_abort = 0;
      if (sel_i && o) begin
        hdr = wide_i ? 11 : 9;
        ok = 0; modif = 1;
        case (cls_i)
          3'd2, 3'd3: ok = (c == hdr + 16);
          3'd4: ok = (c > hdr) && ((c - hdr) % 16 == 0) && ((c - hdr) / 16 <= 4);
          3'd5: ok = (c == hdr);
          default: modif = 0;
        endcase
        e_commit = modif && ok;
        e_abort  = modif && !ok;
        above = (c >= hdr) ? c - hdr : 0;
        w = above / 16;
        e_pw = (w > 7) ? 7 : w;
        c = 0; o = 0;
      end
      m_cnt = c; m_open = o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(commit == e_commit, "R9 model commit", commit, e_commit);
      chk(abort == e_abort, "R6 model abort", abort, e_abort);
      chk(int'(page_words) == e_pw, "R10 model page_words", page_words, e_pw);
    end
  end

  task automatic frame(input int cls, input bit wide, input int n, input int gap,
                       input bit ec, input bit ea, input int epw, input string req);
    @(negedge clk);
    cls_i = 3'(cls); wide_i = wide; start_i = 1; rise_i = 1;
    @(negedge clk);
    start_i = 0; rise_i = 0;
    for (int i = 1; i < n; i++) begin
      repeat (gap) @(negedge clk);
      rise_i = 1;
      @(negedge clk);
      rise_i = 0;
    end
    sel_i = 1;
    @(negedge clk);
    sel_i = 0;
    chk(commit == ec, {req, " commit"}, commit, ec);
    chk(abort == ea, {req, " abort"}, abort, ea);
    chk(int'(page_words) == epw, {req, " page_words"}, page_words, epw);
    @(negedge clk);
    chk(!commit && !abort, "R9 pulse width", {commit, abort}, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!commit && !abort && page_words == 0, "R1 reset", {commit, abort, page_words}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!commit && !abort && page_words == 0, "R1 after reset", {commit, abort, page_words}, 0);

    frame(2, 0, 25, 0, 1, 0, 1, "R3 write narrow 25");
    frame(2, 1, 27, 1, 1, 0, 1, "R3 write wide 27");
    frame(3, 1, 27, 0, 1, 0, 1, "R3 write-all wide 27");
    frame(3, 0, 25, 2, 1, 0, 1, "R2 gaps write-all narrow");
    frame(2, 1, 28, 0, 0, 1, 1, "R6 extra pulse");
    frame(2, 1, 26, 0, 0, 1, 0, "R6 missing pulse");
    frame(2, 0, 27, 0, 0, 1, 1, "R6 narrow given wide length");
    frame(4, 0, 25, 0, 1, 0, 1, "R4 page narrow N1");
    frame(4, 1, 75, 0, 1, 0, 4, "R4 page wide N4");
    frame(4, 1, 43, 1, 1, 0, 2, "R4 page wide N2");
    frame(4, 1, 91, 0, 0, 1, 5, "R4 page N5 rejected");
    frame(4, 1, 11, 0, 0, 1, 0, "R4 page N0 rejected");
    frame(4, 0, 42, 0, 0, 1, 2, "R4 page off by one");
    frame(5, 0, 9, 0, 1, 0, 0, "R5 control narrow 9");
    frame(5, 1, 11, 0, 1, 0, 0, "R5 control wide 11");
    frame(5, 1, 12, 0, 0, 1, 0, "R5 control extra");
    frame(1, 1, 27, 0, 0, 0, 1, "R7 read");
    frame(1, 0, 300, 0, 0, 0, 7, "R7 long read");
    frame(0, 1, 11, 0, 0, 0, 0, "R7 none class");
    frame(2, 1, 283, 0, 0, 1, 7, "R8 wrap alias");

    // R11: closing without an open frame, with stray rises first
    @(negedge clk); cls_i = 3'd5; wide_i = 1; rise_i = 1;
    @(negedge clk); rise_i = 0; sel_i = 1;
    @(negedge clk); sel_i = 0;
    chk(!commit && !abort, "R11 idle fall pulse", {commit, abort}, 0);
    chk(page_words == 3'd7, "R11 page_words held", page_words, 7);
    // R2: stray rises above were not counted into the next frame
    frame(5, 1, 11, 0, 1, 0, 0, "R2 stray rises ignored");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule